// File: doc/BRIEF.md
# PC/SP-Relative Address Generator

This block sits beside the decode stage of a small core that runs a 16-bit instruction encoding. It handles two instruction shapes. The first forms an address and sends it to a general register. The second moves the stack pointer up or down by a word-aligned step. Each cycle it takes an instruction word, the address of that instruction, the present stack pointer and a valid strobe. One clock later it drives either a register write (value plus 3-bit index) or a stack-pointer write, each with its own enable.

The address form takes one of two bases and adds an unsigned 8-bit count of words to it. The first base is the instruction address advanced by four with bit 1 then cleared. The second base is the stack pointer. The stack form holds its 7-bit word count as a magnitude, and a separate sign bit chooses whether that count is added or subtracted. The block has no flag outputs and never disturbs the condition codes. The register file, the memory path and the flag logic all live outside it.

Top module: `rel_addr_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, both write enables are low, even if a valid instruction is presented during reset.
- R2: A word whose bits [15:12] are 1010 is an address instruction. Bits [10:8] give the destination index and bits [7:0] give a word count. One cycle after the strobe, the register write enable is high, the index is output, and the value is the base plus the word count times four.
- R3: If bit 11 of an address instruction is 0, the base is the instruction address plus 4 with bit 1 forced to 0. For example, addresses 0x1000 and 0x1002 both give base 0x1004.
- R4: If bit 11 of an address instruction is 1, the base is the stack-pointer input, used unchanged.
- R5: A word whose bits [15:8] are 10110000 is a stack adjustment. If bit 7 is 0, the stack-pointer write enable goes high one cycle later with the value stack pointer plus bits [6:0] times four (at most 508).
- R6: If bit 7 of a stack adjustment is 1, the same magnitude is subtracted, and the result wraps modulo 2^32.
- R7: A word that matches neither pattern produces no write enable.
- R8: When the valid strobe is low, no write enable is produced, whatever the instruction word.
- R9: The two write enables are never high in the same cycle. Each accepted instruction gives a one-cycle pulse on exactly one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| inst_addr | input | 32 | Address of the instruction |
| sp_in | input | 32 | Current stack pointer |
| rd_we | output | 1 | Register write enable |
| rd_idx | output | 3 | Destination register index |
| rd_value | output | 32 | Value to write to the register |
| sp_we | output | 1 | Stack-pointer write enable |
| sp_value | output | 32 | New stack pointer |

## Verification
The bench presents instruction addresses with bit 1 set and with bit 1 clear. A design that skips the bit-1 clear, or that leaves out the +4 advance, returns an address off by two or four.

It uses the largest word count and the largest magnitude in both directions. It also subtracts below zero. A design that sign-extends the 7-bit field or treats it as two's complement gets the wrong sign or the wrong size at these values, and so does one that truncates the result.

Words close to both patterns are sent to check that the decode uses the full bit pattern. These include other encodings whose upper nibble is 1011, and an address word sent with the strobe low. A design that decodes too few bits would write on them.

// File: rtl/rel_addr_pkg.sv
package rel_addr_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LEA_PC = 2'd1,
    OP_LEA_SP = 2'd2,
    OP_SP_ADJ = 2'd3
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [2:0] dst;
    logic       neg;
    logic [7:0] words;
  } dec_t;
endpackage

// File: rtl/rel_addr_decode.sv
module rel_addr_decode
  import rel_addr_pkg::*;
(
  input  logic [15:0] instr,
  output dec_t        dec
);
  always_comb begin
    dec = '0;
    dec.op = OP_NONE;
    if (instr[15:12] == 4'b1010) begin
      dec.op    = instr[11] ? OP_LEA_SP : OP_LEA_PC;
      dec.dst   = instr[10:8];
      dec.words = instr[7:0];
    end else if (instr[15:8] == 8'b1011_0000) begin
      dec.op    = OP_SP_ADJ;
      dec.neg   = instr[7];
      dec.words = {1'b0, instr[6:0]};
    end
  end
endmodule

// File: rtl/rel_addr_calc.sv
module rel_addr_calc
  import rel_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  dec_t              dec,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] result
);
  localparam int OFF_W = 10;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] pc_base;
  logic [ADDR_W-1:0] base;

  always_comb begin
    offset = '0;
    offset[OFF_W-1:0] = {dec.words, 2'b00};
    pc_base    = pc + ADDR_W'(4);
    pc_base[1] = 1'b0;
    base   = (dec.op == OP_LEA_PC) ? pc_base : sp;
    result = dec.neg ? (base - offset) : (base + offset);
  end
endmodule

// File: rtl/rel_addr_unit.sv
module rel_addr_unit
  import rel_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [15:0]       instr,
  input  logic [ADDR_W-1:0] inst_addr,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              rd_we,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_value,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_value
);
  dec_t              dec;
  logic [ADDR_W-1:0] result;
  logic              is_lea;
  logic              is_adj;

  rel_addr_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  rel_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
    .dec    (dec),
    .pc     (inst_addr),
    .sp     (sp_in),
    .result (result)
  );

  assign is_lea = in_valid && (dec.op == OP_LEA_PC || dec.op == OP_LEA_SP);
  assign is_adj = in_valid && (dec.op == OP_SP_ADJ);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_we    <= 1'b0;
      sp_we    <= 1'b0;
      rd_idx   <= '0;
      rd_value <= '0;
      sp_value <= '0;
    end else begin
      rd_we <= is_lea;
      sp_we <= is_adj;
      if (is_lea) begin
        rd_idx   <= IDX_W'(dec.dst);
        rd_value <= result;
      end
      if (is_adj) begin
        sp_value <= result;
      end
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(rd_we && sp_we)); // R9

  AST_NO_WE_WITHOUT_VALID: assert property (@(posedge clk) disable iff (rst)
    (rd_we || sp_we) |-> $past(in_valid)); // R8

  AST_KNOWN_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (rd_we || sp_we) |-> ($past(instr[15:12]) == 4'b1010 || $past(instr[15:8]) == 8'hB0)); // R7

  AST_PC_BIT1_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_we && !$past(instr[11])) |-> (rd_value[1] == 1'b0)); // R3

  AST_SP_ALIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    sp_we |-> (sp_value[1:0] == $past(sp_in[1:0]))); // R5
endmodule

// File: tb/rel_addr_unit_bench.sv
module rel_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] inst_addr = '0;
  logic [31:0] sp_in = '0;
  logic        rd_we;
  logic [2:0]  rd_idx;
  logic [31:0] rd_value;
  logic        sp_we;
  logic [31:0] sp_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic        rd_we;
    logic [2:0]  rd_idx;
    logic [31:0] rd_value;
    logic        sp_we;
    logic [31:0] sp_value;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  rel_addr_unit u_rel_addr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .inst_addr(inst_addr), .sp_in(sp_in), .rd_we(rd_we), .rd_idx(rd_idx),
    .rd_value(rd_value), .sp_we(sp_we), .sp_value(sp_value)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic v, input logic [15:0] w,
                                 input logic [31:0] pc, input logic [31:0] sp, input string req);
    exp_t e;
    logic [31:0] base;
    e.rd_we = 0; e.sp_we = 0; e.rd_idx = 0; e.rd_value = 0; e.sp_value = 0; e.req = req;
    if (v && w[15:12] == 4'b1010) begin
      base = pc + 32'd4;
      base = {base[31:2], 1'b0, base[0]};
      if (w[11]) base = sp;
      e.rd_we = 1; e.rd_idx = w[10:8];
      e.rd_value = base + {22'd0, w[7:0], 2'b00};
    end else if (v && w[15:8] == 8'hB0) begin
      e.sp_we = 1;
      e.sp_value = w[7] ? sp - {23'd0, w[6:0], 2'b00} : sp + {23'd0, w[6:0], 2'b00};
    end
    return e;
  endfunction

  task automatic drive(input logic v, input logic [15:0] w, input logic [31:0] pc,
                       input logic [31:0] sp, input string req);
    @(negedge clk);
    in_valid = v; instr = w; inst_addr = pc; sp_in = sp;
    sb.push_back(model(v, w, pc, sp, req));
  endtask

  // monitor: sample 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " rd_we"}, {31'd0, rd_we}, {31'd0, e.rd_we});
        check({e.req, " sp_we"}, {31'd0, sp_we}, {31'd0, e.sp_we});
        check("R9 single enable", {31'd0, rd_we & sp_we}, 32'd0);
        if (e.rd_we) begin
          check({e.req, " rd_idx"}, {29'd0, rd_idx}, {29'd0, e.rd_idx});
          check({e.req, " rd_value"}, rd_value, e.rd_value);
        end
        if (e.sp_we) check({e.req, " sp_value"}, sp_value, e.sp_value);
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: valid address instruction during reset must not write
    @(negedge clk);
    in_valid = 1; instr = 16'hA123; inst_addr = 32'h100; sp_in = 32'h2000;
    @(posedge clk); #2;
    check("R1 reset rd_we", {31'd0, rd_we}, 32'd0);
    check("R1 reset sp_we", {31'd0, sp_we}, 32'd0);
    @(negedge clk);
    in_valid = 0;
    rst = 0;
    @(posedge clk); #2;
    check("R1 after reset rd_we", {31'd0, rd_we}, 32'd0);
    check("R1 after reset sp_we", {31'd0, sp_we}, 32'd0);

    // R2/R3: PC base, aligned and bit-1-set addresses
    drive(1, 16'hA305, 32'h0000_1000, 32'h8000, "R3 pc aligned");
    drive(1, 16'hA305, 32'h0000_1002, 32'h8000, "R3 pc bit1 set");
    drive(1, 16'hA7FF, 32'hFFFF_FFFA, 32'h8000, "R2 pc max word8 wrap");
    drive(1, 16'hA000, 32'h0000_2006, 32'h8000, "R2 zero offset");
    // R4: SP base
    drive(1, 16'hAC10, 32'h0000_1000, 32'h0001_0000, "R4 sp base");
    drive(1, 16'hADFF, 32'h0000_1000, 32'h0000_7FF4, "R4 sp max");
    // R5/R6: stack adjust
    drive(1, 16'hB07F, 32'h0, 32'h0000_1000, "R5 add max 508");
    drive(1, 16'hB001, 32'h0, 32'h0000_1000, "R5 add 4");
    drive(1, 16'hB0FF, 32'h0, 32'h0000_1000, "R6 sub max 508");
    drive(1, 16'hB088, 32'h0, 32'h0000_0010, "R6 sub wrap");
    drive(1, 16'hB080, 32'h0, 32'h0000_0ABC, "R6 sub zero");
    // R7: near-miss encodings
    drive(1, 16'hB100, 32'h0, 32'h1000, "R7 1011 other");
    drive(1, 16'hB47F, 32'h0, 32'h1000, "R7 1011 list form");
    drive(1, 16'h9012, 32'h0, 32'h1000, "R7 1001 form");
    drive(1, 16'hE001, 32'h0, 32'h1000, "R7 branch form");
    drive(1, 16'hB880, 32'h0, 32'h1000, "R7 bit11 set");
    // R8: strobe low
    drive(0, 16'hA4FF, 32'h1000, 32'h1000, "R8 invalid lea");
    drive(0, 16'hB07F, 32'h1000, 32'h1000, "R8 invalid adj");
    // R9: back-to-back alternating forms
    drive(1, 16'hA201, 32'h0000_4002, 32'h3000, "R9 lea then adj");
    drive(1, 16'hB002, 32'h0000_4004, 32'h3000, "R9 adj after lea");
    drive(1, 16'hAE02, 32'h0000_4006, 32'h3000, "R9 lea after adj");
    drive(0, 16'h0000, 32'h0, 32'h0, "R9 idle");
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule